// File: doc/BRIEF.md
# Serial Control Word Transmitter

This block is the controller side of a three-wire serial control link. A single start request launches one transfer. The block captures an 11-bit control word and the speed choice into holding registers. It then drives a serial clock, a data line and a latch strobe. The receiver at the other end shifts data in on each rising clock edge and copies its shift register to its outputs when the strobe rises. The block also drives an active-low reset line toward the receiver, with a guaranteed minimum low time.

All timing comes from one system clock. A half-period timer counts system cycles. Its length is chosen per transfer, either the fast setting (at most 500 kHz serial clock) or the slow one (about 250 kHz). A phase counter steps once per half period and stops the sequence when it reaches a terminal value. Each half period is at least 1 µs at the default parameters, so every data setup, data hold and latch spacing limit holds with margin.

A transfer sends one dummy slot and then the 11 word bits, starting with bit 0. Each slot lasts two half periods. In the first half the clock is low and the new data bit is presented. In the second half the clock is high. After the last data slot the clock is held high for one more half period, and the strobe rises at the start of that half. The clock then falls while the strobe is still high. One half period later the strobe drops, the line returns to idle, and a one-cycle done pulse is given.

Top module: `ctrl_word_tx`

## Requirements
- R1: While `rst_n` is low, `sclk`, `sdata`, `slatch` and `done` are 0, `rx_rst_n` is 0 and `busy` is 1. After release, `rx_rst_n` stays low until the RST_LEN-th rising clock edge, and `busy` stays high for the same time.
- R2: The half period L equals FAST_HALF system cycles when `fast` was 1 at the accepted start, and SLOW_HALF otherwise. A transfer occupies 26·L cycles.
- R3: Half period p (0 to 25) begins L·p cycles after the edge that accepts `start`. During half p, `sdata` carries slot s = p/2. Slot 0 is the dummy 0. Slot s from 1 to 11 carries word bit s−1. `sdata` keeps word bit 10 through halves 24 and 25, so it changes only at the start of even halves.
- R4: `sclk` is low in even halves 0 to 22 and high in odd halves 1 to 23, which gives exactly 12 rising edges. It is also high in half 24 and low in half 25.
- R5: `slatch` is high only in halves 24 and 25. It rises while `sclk` is high and one full half period after `sclk` rose, and `sclk` stays high for one more half period after that.
- R6: At the edge that ends half 25, `sclk`, `sdata` and `slatch` return to 0, `busy` falls, and `done` is 1 for exactly one cycle.
- R7: A `start` that is seen while `busy` is 1 has no effect. This covers both a running transfer and a running reset pulse.
- R8: `word` and `fast` are sampled only at the accepted start. Changes to them during a transfer do not alter the serial output.
- R9: `rst_req` seen while not busy drives `rx_rst_n` low for exactly RST_LEN cycles, and `busy` is high during that time. If `start` arrives in the same cycle, the reset wins and the start is dropped. A `rst_req` during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start | input | 1 | Request to send one control word |
| fast | input | 1 | Speed choice: 1 selects the fast serial clock |
| word | input | NBITS | Control word; bit 0 is sent first |
| rst_req | input | 1 | Request for a reset pulse toward the receiver |
| sclk | output | 1 | Serial clock, idle low |
| sdata | output | 1 | Serial data |
| slatch | output | 1 | Latch strobe, idle low |
| rx_rst_n | output | 1 | Active-low reset toward the receiver |
| busy | output | 1 | A transfer or reset pulse is running |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Every output is registered. The values for half period p therefore appear right after the system edge numbered L·p, counting from the edge that takes `start`. The end-of-transfer values and `done` appear after edge 26·L. A reset pulse releases `rx_rst_n` after edge RST_LEN, counting from the edge that takes the request. The bench counts edges from the accepting edge and samples every output on the following falling edge, for each cycle of each transfer. It compares each sample with a value derived from the half index and the captured word and speed. This covers both speeds, walking-one and alternating words, and transfers disturbed by new requests and new input values mid-way.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

  // system cycles in one serial half period for the chosen speed
  function automatic int half_cycles(logic fast, int fast_half, int slow_half);
    return fast ? fast_half : slow_half;
  endfunction

  // index of the final half period: (dummy + nbits) slots of two halves, then two latch halves
  function automatic int last_half(int nbits);
    return 2 * (nbits + 1) + 1;
  endfunction

  // serial clock level in half p
  function automatic logic clk_level(int p, int nbits);
    if (p < 2 * (nbits + 1)) return (p % 2) == 1;
    return p == 2 * (nbits + 1);
  endfunction

  // strobe level in half p
  function automatic logic latch_level(int p, int nbits);
    return p >= 2 * (nbits + 1);
  endfunction

  // position in {word, dummy} presented during half p
  function automatic int data_slot(int p, int nbits);
    int s;
    s = p / 2;
    return (s > nbits) ? nbits : s;
  endfunction

endpackage

// File: rtl/sctx_half_timer.sv
module sctx_half_timer #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] len,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (tick)              cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R2: the half-period count never passes the selected length
  p_half_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < len));

endmodule

// File: rtl/sctx_reset_pulse.sv
module sctx_reset_pulse #(
  parameter int unsigned RST_LEN = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_low
);
  localparam int unsigned RW = $clog2(RST_LEN + 1);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_low <= 1'b1;
      cnt       <= RW'(RST_LEN - 1);
    end else if (fire && !pulse_low) begin
      pulse_low <= 1'b1;
      cnt       <= RW'(RST_LEN - 1);
    end else if (pulse_low) begin
      if (cnt == '0) pulse_low <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  // R9: the remaining count stays inside the pulse length
  p_pulse_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_low |-> (cnt < RW'(RST_LEN)));

endmodule

// File: rtl/sctx_sequencer.sv
module sctx_sequencer
  import sctx_pkg::*;
#(
  parameter int unsigned NBITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             blocked,
  input  logic             fast,
  input  logic [NBITS-1:0] word,
  input  logic             tick,
  output logic             go,
  output logic             active,
  output logic             fast_q,
  output logic             sclk,
  output logic             sdata,
  output logic             slatch,
  output logic             done
);
  localparam int LASTH = last_half(NBITS);
  localparam int PW    = $clog2(LASTH + 1);
  localparam int SW    = $clog2(NBITS + 1);

  logic [PW-1:0]    phase, phase_nx;
  logic [NBITS-1:0] word_q;
  logic [NBITS:0]   ext;
  logic [SW-1:0]    sel_nx;
  logic             at_term;

  assign go       = start && !active && !blocked;
  assign at_term  = (phase == PW'(LASTH));
  assign phase_nx = phase + 1'b1;
  assign sel_nx   = SW'(data_slot(int'(phase_nx), NBITS));
  assign ext      = {word_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; phase <= '0; word_q <= '0; fast_q <= 1'b0;
      sclk <= 1'b0; sdata <= 1'b0; slatch <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        active <= 1'b1; phase <= '0; word_q <= word; fast_q <= fast;
        sclk <= 1'b0; sdata <= 1'b0; slatch <= 1'b0;
      end else if (active && tick) begin
        if (at_term) begin
          active <= 1'b0; phase <= '0;
          sclk <= 1'b0; sdata <= 1'b0; slatch <= 1'b0; done <= 1'b1;
        end else begin
          phase  <= phase_nx;
          sclk   <= clk_level(int'(phase_nx), NBITS);
          sdata  <= ext[sel_nx];
          slatch <= latch_level(int'(phase_nx), NBITS);
        end
      end
    end
  end

  // R3: data never moves on a rising serial clock edge
  p_data_steady_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));

  // R5: the strobe rises under a high clock with data unchanged
  p_latch_under_high_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slatch) |-> (sclk && $stable(sdata)));

  // R6: done comes with the strobe falling
  p_done_with_latch_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(slatch));

  // R7: a start during a transfer does not restart the phase count
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active && !tick) |=> (phase == $past(phase)));

  // R8: the captured word holds for the whole transfer
  p_word_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(word_q));

endmodule

// File: rtl/ctrl_word_tx.sv
module ctrl_word_tx
  import sctx_pkg::*;
#(
  parameter int unsigned NBITS     = 11,
  parameter int unsigned FAST_HALF = 260,
  parameter int unsigned SLOW_HALF = 510,
  parameter int unsigned RST_LEN   = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fast,
  input  logic [NBITS-1:0] word,
  input  logic             rst_req,
  output logic             sclk,
  output logic             sdata,
  output logic             slatch,
  output logic             rx_rst_n,
  output logic             busy,
  output logic             done
);
  localparam int unsigned MAXH = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int unsigned HW   = $clog2(MAXH + 1);

  logic          xfer_active, xfer_go, fast_q, half_tick, rst_low, rst_fire;
  logic [HW-1:0] half_len;

  assign busy     = xfer_active || rst_low;
  assign rst_fire = rst_req && !busy;
  assign rx_rst_n = !rst_low;
  assign half_len = HW'(half_cycles(fast_q, FAST_HALF, SLOW_HALF));

  sctx_half_timer #(.CW(HW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(xfer_active), .restart(xfer_go),
    .len(half_len), .tick(half_tick)
  );

  sctx_reset_pulse #(.RST_LEN(RST_LEN)) u_rpulse (
    .clk(clk), .rst_n(rst_n), .fire(rst_fire), .pulse_low(rst_low)
  );

  sctx_sequencer #(.NBITS(NBITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .blocked(rst_low || rst_req),
    .fast(fast), .word(word), .tick(half_tick), .go(xfer_go),
    .active(xfer_active), .fast_q(fast_q), .sclk(sclk), .sdata(sdata),
    .slatch(slatch), .done(done)
  );

  // R9: no transfer runs while the receiver is held in reset
  p_no_xfer_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rst_n |-> !xfer_active);

  // R6: done lasts a single cycle
  p_single_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/ctrl_word_tx_tb.sv
`timescale 1ns/1ps
module ctrl_word_tx_tb;
  localparam int N  = 11;
  localparam int FH = 3;
  localparam int SH = 5;
  localparam int RL = 7;

  logic clk = 0, rst_n = 0, start = 0, fast = 0, rst_req = 0;
  logic [N-1:0] word = '0;
  logic sclk, sdata, slatch, rx_rst_n, busy, done;
  int total = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ctrl_word_tx #(.NBITS(N), .FAST_HALF(FH), .SLOW_HALF(SH), .RST_LEN(RL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fast(fast), .word(word),
    .rst_req(rst_req), .sclk(sclk), .sdata(sdata), .slatch(slatch),
    .rx_rst_n(rx_rst_n), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected waveform restated from the requirements
  function automatic logic e_clk(int p);
    if (p >= 24) return p == 24;
    return (p & 1) == 1;
  endfunction

  function automatic logic e_data(int p, logic [N-1:0] w);
    int s = p / 2;
    if (s == 0) return 1'b0;
    if (s <= N) return w[s-1];
    return w[N-1];
  endfunction

  task automatic run_xfer(input logic [N-1:0] w, input logic f, input bit disturb);
    int L, lim, p;
    L = f ? FH : SH;
    lim = 26 * L;
    @(negedge clk); start = 1; word = w; fast = f;
    @(posedge clk);
    for (int k = 0; k <= lim + 1; k++) begin
      @(negedge clk);
      if (k < lim) begin
        p = k / L;
        chk(sclk == e_clk(p), "R2 R4 sclk", sclk, e_clk(p));
        chk(sdata == e_data(p, w), disturb ? "R8 sdata" : "R3 sdata", sdata, e_data(p, w));
        chk(slatch == (p >= 24), "R5 slatch", slatch, p >= 24);
        chk(busy == 1, disturb ? "R7 busy" : "R6 busy", busy, 1);
        chk(done == 0, "R6 done", done, 0);
        chk(rx_rst_n == 1, "R9 rx_rst_n", rx_rst_n, 1);
      end else begin
        chk(done == (k == lim), "R6 done", done, k == lim);
        chk(busy == 0, "R6 busy", busy, 0);
        chk({sclk, sdata, slatch} == 3'b000, "R6 idle lines", {sclk, sdata, slatch}, 0);
      end
      if (k == 0) start = 0;
      if (disturb && k == 5 * L) begin
        start = 1; word = ~w; fast = ~f; rst_req = 1;
      end
      if (disturb && k == 5 * L + 1) begin
        start = 0; rst_req = 0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sclk, sdata, slatch, done} == 4'b0, "R1 lines in reset", {sclk, sdata, slatch, done}, 0);
    chk(rx_rst_n == 0, "R1 rx_rst_n in reset", rx_rst_n, 0);
    chk(busy == 1, "R1 busy in reset", busy, 1);
    rst_n = 1; start = 1; word = '1; fast = 1;
    for (int j = 1; j <= RL; j++) begin
      @(negedge clk);
      chk(rx_rst_n == (j >= RL), "R1 rx_rst_n after release", rx_rst_n, j >= RL);
      chk(busy == (j < RL), "R1 busy after release", busy, j < RL);
      if (j == RL) start = 0;
    end
    @(negedge clk);
    chk(busy == 0 && sclk == 0, "R7 start during reset pulse", busy, 0);

    run_xfer(11'h000, 1'b1, 0);
    run_xfer(11'h7FF, 1'b0, 0);
    run_xfer(11'h555, 1'b1, 0);
    run_xfer(11'h2AA, 1'b0, 0);
    for (int b = 0; b < N; b++) begin
      run_xfer(11'(1 << b), 1'b1, 0);
      run_xfer(11'(1 << b), 1'b0, 0);
    end
    run_xfer(11'h4B3, 1'b1, 1);
    run_xfer(11'h1C6, 1'b0, 1);

    // R9 reset request with a simultaneous start
    @(negedge clk); rst_req = 1; start = 1; word = 11'h3F0; fast = 1;
    @(posedge clk);
    for (int k = 0; k <= RL; k++) begin
      @(negedge clk);
      chk(rx_rst_n == (k >= RL), "R9 rx_rst_n pulse", rx_rst_n, k >= RL);
      chk(busy == (k < RL), "R9 busy in pulse", busy, k < RL);
      chk(sclk == 0, "R9 start dropped", sclk, 0);
      if (k == 0) begin rst_req = 0; start = 0; end
    end
    run_xfer(11'h3F0, 1'b1, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule